// File: doc/BRIEF.md
# Receive FIFO Trigger, Character Timeout and DMA Request Pins

This block serves one serial channel. It takes the receive and transmit FIFO occupancy counts and produces the signals that depend on FIFO level. These are a receive trigger flag, a receive character timeout flag, and the two active-low DMA request pins: receive-ready and transmit-ready. The FIFOs, the serial shifters and the baud generator sit outside the block. The receiver supplies a strobe at the centre of each received stop bit. The host side supplies a strobe for each read of the receive holding register.

The timeout counter counts 16x baud ticks. Every 16 ticks make one bit time. The timeout window is four bit times per programmed data bit plus twelve. The two DMA pins work in one of two modes. In single-transfer mode the pins track whether data is present. In block mode the receive pin uses the trigger or the timeout, and the transmit pin reflects whether the transmit FIFO is full.

Top module: `rx_fifo_dma_ctl`

## Requirements
- R1: `rx_trig` is 1 when FIFOs are enabled and the receive count is at least the threshold picked by `trig_sel`: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. Otherwise it is 0.
- R2: `wlen_sel` encodes 5, 6, 7 or 8 data bits as 00, 01, 10 or 11. Take a restart followed by a non-empty FIFO in FIFO mode. `rx_timeout` rises right after the tick that completes 16 × (4 × bits + 12) ticks, and not before that tick.
- R3: A `stop_mid` or `rhr_rd` pulse restarts the timeout count from zero.
- R4: `rx_timeout` stays 0 while the receive FIFO is empty or FIFOs are disabled.
- R5: A `rhr_rd` or `stop_mid` pulse clears `rx_timeout` on the next cycle.
- R6: Single-transfer mode applies when `fifo_en`=0 or `dma_mode`=0. In that mode `rxrdy_n` is 0 exactly when the receive count is non-zero.
- R7: In single-transfer mode `txrdy_n` is 0 exactly when the transmit count is zero.
- R8: Block mode applies when `fifo_en`=1 and `dma_mode`=1. In block mode `rxrdy_n` goes to 0 once `rx_trig` or `rx_timeout` is seen. It then stays 0 until the receive count reaches zero, even if the count drops below the threshold or the timeout clears.
- R9: In block mode `txrdy_n` is 1 only while the transmit count equals the FIFO depth (16).
- R10: After reset, `txrdy_n`=0, `rxrdy_n`=1, `rx_trig`=0 and `rx_timeout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| fifo_en | input | 1 | FIFO mode enable |
| dma_mode | input | 1 | 0 = single-transfer mode, 1 = block mode |
| trig_sel | input | 2 | Receive trigger threshold select |
| wlen_sel | input | 2 | Programmed data bits select |
| tick16 | input | 1 | One-cycle pulse at 16x baud rate |
| stop_mid | input | 1 | Pulse at centre of a received stop bit |
| rhr_rd | input | 1 | Pulse on a receive holding register read |
| rx_count | input | 5 | Receive FIFO occupancy |
| tx_count | input | 5 | Transmit FIFO occupancy |
| rx_trig | output | 1 | Receive trigger level reached |
| rx_timeout | output | 1 | Receive character timeout flag |
| rxrdy_n | output | 1 | Receive DMA request, active low |
| txrdy_n | output | 1 | Transmit DMA request, active low |

## Verification
Suppose the timeout sub-counter or bit counter slips or fails to restart. Then `rx_timeout` rises one bit time early or late, which is 16 ticks off a window of at most 704 ticks. The bench brackets the exact final tick, so the fault shows within one character window. A lost sticky arm state shows at `rxrdy_n` in block mode as soon as the count falls below the threshold while the FIFO is still not empty. Mode decoding faults show at the DMA pins within two cycles of a count change.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  // receive threshold chosen by the 2-bit select
  function automatic int unsigned trig_threshold(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // data bits for a word length select code
  function automatic int unsigned data_bits(input logic [1:0] wsel);
    return 32'(wsel) + 5;
  endfunction

  // timeout window in bit times
  function automatic int unsigned timeout_bits(input logic [1:0] wsel);
    return 4 * data_bits(wsel) + 12;
  endfunction

endpackage

// File: rtl/rxdma_trigger.sv
module rxdma_trigger #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] rx_count,
  output logic          trig_q
);
  import rxdma_pkg::*;

  logic [CW-1:0] level;
  logic          reached;

  assign level   = CW'(trig_threshold(trig_sel));
  assign reached = fifo_en && (rx_count >= level);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= reached;
  end
endmodule

// File: rtl/rxdma_timeout.sv
module rxdma_timeout #(
  parameter int OVS = 16,
  parameter int BW  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic          tick,
  input  logic [BW-1:0] limit,
  output logic          expire,
  output logic          flag_q
);
  localparam int SW = (OVS > 1) ? $clog2(OVS) : 1;

  logic [SW-1:0] sub_q;
  logic [BW-1:0] bits_q;
  logic          sub_wrap;

  assign sub_wrap = (sub_q == SW'(OVS - 1));
  assign expire   = run && !restart && !flag_q && tick && sub_wrap &&
                    ((bits_q + BW'(1)) == limit);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sub_q  <= '0;
      bits_q <= '0;
      flag_q <= 1'b0;
    end else if (restart || !run) begin
      sub_q  <= '0;
      bits_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (tick && !flag_q) begin
        if (sub_wrap) begin
          sub_q  <= '0;
          bits_q <= bits_q + BW'(1);
        end else begin
          sub_q  <= sub_q + SW'(1);
        end
      end
      if (expire) flag_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rxdma_pins.sv
module rxdma_pins #(
  parameter int CW    = 5,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          block_mode,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          trig_q,
  input  logic          tmo_q,
  output logic          armed_q,
  output logic          rxrdy_n,
  output logic          txrdy_n
);
  logic rx_empty, tx_empty, tx_full, armed_d;

  assign rx_empty = (rx_count == '0);
  assign tx_empty = (tx_count == '0);
  assign tx_full  = (tx_count == CW'(DEPTH));
  assign armed_d  = rx_empty ? 1'b0 : (armed_q || trig_q || tmo_q);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      armed_q <= 1'b0;
      rxrdy_n <= 1'b1;
      txrdy_n <= 1'b0;
    end else begin
      armed_q <= armed_d;
      if (block_mode) begin
        rxrdy_n <= !armed_d;
        txrdy_n <= tx_full;
      end else begin
        rxrdy_n <= rx_empty;
        txrdy_n <= !tx_empty;
      end
    end
  end
endmodule

// File: rtl/rx_fifo_dma_ctl.sv
module rx_fifo_dma_ctl #(
  parameter int DEPTH    = 16,
  parameter int OVS      = 16,
  parameter int MAX_BITS = 8,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int BW      = $clog2(4 * MAX_BITS + 12 + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          dma_mode,
  input  logic [1:0]    trig_sel,
  input  logic [1:0]    wlen_sel,
  input  logic          tick16,
  input  logic          stop_mid,
  input  logic          rhr_rd,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  output logic          rx_trig,
  output logic          rx_timeout,
  output logic          rxrdy_n,
  output logic          txrdy_n
);
  import rxdma_pkg::*;

  logic          block_mode;
  logic          tmo_run;
  logic          tmo_restart;
  logic          tmo_expire;
  logic          rx_armed;
  logic [BW-1:0] tmo_limit;

  assign block_mode  = fifo_en && dma_mode;
  assign tmo_run     = fifo_en && (rx_count != '0);
  assign tmo_restart = stop_mid || rhr_rd;
  assign tmo_limit   = BW'(timeout_bits(wlen_sel));

  rxdma_trigger #(.CW(CW)) u_trig (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .rx_count(rx_count), .trig_q(rx_trig)
  );

  rxdma_timeout #(.OVS(OVS), .BW(BW)) u_tmo (
    .clk(clk), .rst(rst), .run(tmo_run), .restart(tmo_restart),
    .tick(tick16), .limit(tmo_limit), .expire(tmo_expire),
    .flag_q(rx_timeout)
  );

  rxdma_pins #(.CW(CW), .DEPTH(DEPTH)) u_pins (
    .clk(clk), .rst(rst), .block_mode(block_mode), .rx_count(rx_count),
    .tx_count(tx_count), .trig_q(rx_trig), .tmo_q(rx_timeout),
    .armed_q(rx_armed), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
  );
endmodule

// File: rtl/rx_fifo_dma_chk.sv
module rx_fifo_dma_chk #(
  parameter int CW    = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_en,
  input logic          dma_mode,
  input logic          tick16,
  input logic          stop_mid,
  input logic          rhr_rd,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rx_timeout,
  input logic          rxrdy_n,
  input logic          txrdy_n,
  input logic          rx_armed,
  input logic          tmo_expire
);
  p_empty_no_timeout_r4: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en || rx_count == '0) |=> !rx_timeout);

  p_strobe_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (rhr_rd || stop_mid) |=> !rx_timeout);

  p_rise_after_tick_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_timeout) |-> ($past(tick16) && $past(tmo_expire)));

  p_single_rx_r6: assert property (@(posedge clk) disable iff (rst)
    !(fifo_en && dma_mode) |=> (rxrdy_n == ($past(rx_count) == '0)));

  p_block_tx_r9: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && dma_mode) |=> (txrdy_n == ($past(tx_count) == CW'(DEPTH))));

  p_block_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && dma_mode && rx_armed && rx_count != '0) |=> !rxrdy_n);
endmodule

bind rx_fifo_dma_ctl rx_fifo_dma_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_mode(dma_mode),
  .tick16(tick16), .stop_mid(stop_mid), .rhr_rd(rhr_rd),
  .rx_count(rx_count), .tx_count(tx_count), .rx_timeout(rx_timeout),
  .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n), .rx_armed(rx_armed),
  .tmo_expire(tmo_expire)
);

// File: tb/sim_rx_fifo_dma_ctl.sv
`timescale 1ns/1ps
module sim_rx_fifo_dma_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b0, dma_mode = 1'b0;
  logic [1:0] trig_sel = 2'd0, wlen_sel = 2'd0;
  logic       tick16 = 1'b0, stop_mid = 1'b0, rhr_rd = 1'b0;
  logic [4:0] rx_count = '0, tx_count = '0;
  logic       rx_trig, rx_timeout, rxrdy_n, txrdy_n;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rx_fifo_dma_ctl u0 (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_mode(dma_mode),
    .trig_sel(trig_sel), .wlen_sel(wlen_sel), .tick16(tick16),
    .stop_mid(stop_mid), .rhr_rd(rhr_rd), .rx_count(rx_count),
    .tx_count(tx_count), .rx_trig(rx_trig), .rx_timeout(rx_timeout),
    .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
  );

  // fe, md, trig_sel, rx_count, tx_count -> rxrdy_n, txrdy_n, rx_trig
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0,1'b0,2'd0,5'd0, 5'd0, 1'b1,1'b0,1'b0},
    {1'b0,1'b0,2'd0,5'd1, 5'd1, 1'b0,1'b1,1'b0},
    {1'b1,1'b0,2'd2,5'd3, 5'd0, 1'b0,1'b0,1'b0},
    {1'b1,1'b0,2'd2,5'd8, 5'd5, 1'b0,1'b1,1'b1},
    {1'b1,1'b1,2'd0,5'd1, 5'd0, 1'b0,1'b0,1'b1},
    {1'b1,1'b1,2'd1,5'd3, 5'd15,1'b1,1'b0,1'b0},
    {1'b1,1'b1,2'd1,5'd4, 5'd16,1'b0,1'b1,1'b1},
    {1'b1,1'b1,2'd2,5'd7, 5'd16,1'b1,1'b1,1'b0},
    {1'b1,1'b1,2'd3,5'd13,5'd1, 1'b1,1'b0,1'b0},
    {1'b1,1'b1,2'd3,5'd14,5'd0, 1'b0,1'b0,1'b1},
    {1'b0,1'b1,2'd3,5'd0, 5'd1, 1'b1,1'b1,1'b0},
    {1'b1,1'b1,2'd2,5'd8, 5'd0, 1'b0,1'b0,1'b1},
    {1'b1,1'b0,2'd3,5'd14,5'd16,1'b0,1'b1,1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick16 = 1'b1; @(negedge clk);
      tick16 = 1'b0; @(negedge clk);
    end
  endtask

  task automatic pulse_rd();
    rhr_rd = 1'b1; @(negedge clk); rhr_rd = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_stop();
    stop_mid = 1'b1; @(negedge clk); stop_mid = 1'b0; @(negedge clk);
  endtask

  function automatic int window_ticks(input logic [1:0] w);
    return 16 * ((int'(w) + 5) * 4 + 12);
  endfunction

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R10 txrdy_n", txrdy_n, 0);
    chk("R10 rxrdy_n", rxrdy_n, 1);
    chk("R10 rx_trig", rx_trig, 0);
    chk("R10 rx_timeout", rx_timeout, 0);
    rst = 1'b0;
    cyc(2);

    // table of static level cases: R1 R6 R7 R8 R9
    for (int k = 0; k < NV; k++) begin
      rx_count = '0; tx_count = '0;
      cyc(3);
      fifo_en  = VEC[k][16];
      dma_mode = VEC[k][15];
      trig_sel = VEC[k][14:13];
      rx_count = VEC[k][12:8];
      tx_count = VEC[k][7:3];
      cyc(4);
      chk("R6 R8 rxrdy_n", rxrdy_n, VEC[k][2]);
      chk("R7 R9 txrdy_n", txrdy_n, VEC[k][1]);
      chk("R1 rx_trig", rx_trig, VEC[k][0]);
    end

    // R8: sticky after trigger, release only when empty
    fifo_en = 1; dma_mode = 1; trig_sel = 2'd3; tx_count = 0;
    rx_count = 0; cyc(3);
    rx_count = 14; cyc(4);
    chk("R8 armed by trigger", rxrdy_n, 0);
    rx_count = 3; cyc(4);
    chk("R8 holds below threshold", rxrdy_n, 0);
    rx_count = 0; cyc(3);
    chk("R8 released on empty", rxrdy_n, 1);

    // R2 exact window for several word lengths
    for (int w = 0; w < 4; w += 3) begin
      wlen_sel = 2'(w);
      rx_count = 2; cyc(2);
      pulse_rd();
      ticks(window_ticks(2'(w)) - 1);
      cyc(2);
      chk("R2 no flag one tick early", rx_timeout, 0);
      chk("R8 not armed before timeout", rxrdy_n, 1);
      ticks(1);
      cyc(1);
      chk("R2 flag at window end", rx_timeout, 1);
      cyc(2);
      chk("R8 armed by timeout", rxrdy_n, 0);
      pulse_rd();
      chk("R5 read clears flag", rx_timeout, 0);
      cyc(2);
      chk("R8 holds after flag clear", rxrdy_n, 0);
      rx_count = 0; cyc(3);
      chk("R8 released on empty", rxrdy_n, 1);
    end

    // R3 restart by read and by stop-centre strobe
    wlen_sel = 2'd2; rx_count = 2; cyc(2);
    pulse_rd();
    ticks(window_ticks(2'd2) - 16);
    pulse_rd();
    ticks(window_ticks(2'd2) - 1);
    cyc(2);
    chk("R3 read restarts count", rx_timeout, 0);
    pulse_stop();
    ticks(window_ticks(2'd2) - 1);
    cyc(2);
    chk("R3 stop strobe restarts count", rx_timeout, 0);
    ticks(1); cyc(1);
    chk("R2 flag after full window", rx_timeout, 1);
    pulse_stop();
    chk("R5 stop strobe clears flag", rx_timeout, 0);

    // R4 empty FIFO or FIFO disabled: no timeout
    rx_count = 0; pulse_rd();
    ticks(window_ticks(2'd2) + 20);
    cyc(2);
    chk("R4 empty fifo no timeout", rx_timeout, 0);
    fifo_en = 0; rx_count = 3; pulse_rd();
    ticks(window_ticks(2'd2) + 20);
    cyc(2);
    chk("R4 fifo disabled no timeout", rx_timeout, 0);
    chk("R6 single mode rxrdy with data", rxrdy_n, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule